// File: doc/BRIEF.md
# Event-Sampled PI Voltage Loop with Multiplexed Current Reference

This block is the digital voltage loop of a hysteretic current controller. It watches the high-side gate drive of a buck stage and forms a sampling strobe from its switching edges. When switching stalls, a programmable uniform tick takes over. On every strobe it takes one signed error sample and updates a saturating fixed-point PI controller. From the controller output it produces one current-reference word for a single external DAC. The word changes with the gate level, so one converter supplies both the upper and the lower comparator threshold.

Three reference arrangements are supported. The controller output can be the upper threshold, the lower threshold, or the centre of the band. A period counter reports the number of clock cycles since the last switching strobe, so a frequency loop elsewhere can adjust the band. The ADC, DAC, comparator and power stage are outside the block.

Top module: `hcc_volt_loop`

## Requirements
- R1: While rst_ni is low, dac_o, period_o and the internal controller state are 0, and strobe_o is 0. fallback_o is 0 when thresh_i is non-zero.
- R2: In mode codes 0 (peak), 2 (average) and 3 (alias of peak), each rising edge of gate_i produces exactly one strobe_o pulse one clock wide, after a two-flop synchronizer. Falling edges produce none.
- R3: In mode code 1 (valley), only falling edges of gate_i produce a strobe. Rising edges produce none.
- R4: period_o is 0 in the cycle after an edge strobe. It then rises by one per clock and holds at 2^CW-1.
- R5: fallback_o is high whenever period_o >= thresh_i. While it is high, a strobe also fires every uperiod_i clocks, the first one uperiod_i clocks into the fallback; a value of 0 or 1 means every clock. A gate edge still strobes and ends the fallback.
- R6: On a strobe with error e, unsigned gains kp and ki (2 fraction bits) and integrator u: u' = sat(u + floor(ki*e/4)) and vc = sat(floor(kp*e/4) + u').
- R7: The integrator and vc saturate to [0, 2^DW-1] and never wrap.
- R8: Between strobes, vc and the integrator hold, whatever err_i does.
- R9: Peak mode: dac_o is vc while the synchronized gate is high and sat(vc - band_i) while it is low.
- R10: Valley mode: dac_o is vc while the gate is low and sat(vc + band_i) while it is high.
- R11: Average mode: dac_o is sat(vc + floor(band_i/2)) while the gate is high and sat(vc - floor(band_i/2)) while it is low. Code 3 behaves as peak.
- R12: mode_i is taken only on a strobe. A change between strobes alters neither dac_o nor the edge polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | High-side gate level, asynchronous |
| mode_i | input | 2 | Reference arrangement: 0 peak, 1 valley, 2 average, 3 peak |
| err_i | input | EW | Signed error sample (reference minus output) |
| kp_i | input | GW | Proportional gain, 2 fraction bits |
| ki_i | input | GW | Integral gain, 2 fraction bits |
| band_i | input | DW | Hysteresis band in DAC codes |
| thresh_i | input | CW | Stall threshold for the uniform fallback |
| uperiod_i | input | CW | Uniform tick period in clocks |
| dac_o | output | DW | Registered current-reference word |
| period_o | output | CW | Clocks since the last edge strobe, saturating |
| strobe_o | output | 1 | Sampling strobe |
| fallback_o | output | 1 | Uniform sampling selected |

## Verification
A wrong integrator or vc appears on dac_o one clock after the strobe that set it. The wrong value then persists on both gate levels until a later strobe, so each step of a swept error sequence exposes it. A wrong captured mode or edge polarity appears as a missing or extra strobe within three clocks of a gate edge, and as a wrong threshold on the following reference word. A fault in the period counter or the uniform counter shows as a changed count on period_o. It also moves the cycle in which fallback_o rises and shifts how many strobes fall in a fixed window of stalled switching.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  typedef enum logic [1:0] {
    MODE_PEAK     = 2'd0,
    MODE_VALLEY   = 2'd1,
    MODE_AVG      = 2'd2,
    MODE_PEAK_ALT = 2'd3
  } ref_mode_e;
endpackage

// File: rtl/hcc_gate_edge.sv
module hcc_gate_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic use_fall_i,
  output logic gate_s_o,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], gate_i};
  end

  assign gate_s_o = sh_q[SYNC_STAGES-1];
  assign edge_o   = use_fall_i ? (sh_q[SYNC_STAGES] & ~gate_s_o)
                               : (gate_s_o & ~sh_q[SYNC_STAGES]);
endmodule

// File: rtl/hcc_sample_timer.sv
module hcc_sample_timer #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          edge_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [CW-1:0] uperiod_i,
  output logic [CW-1:0] period_o,
  output logic          fallback_o,
  output logic          strobe_o
);
  localparam logic [CW-1:0] VT_MAX = {CW{1'b1}};

  logic [CW-1:0] vt_q, uc_q;
  logic          tick;

  assign fallback_o = (vt_q >= thresh_i);
  // uperiod of 0 or 1 ticks every clock
  assign tick     = fallback_o && (({1'b0, uc_q} + (CW+1)'(1)) >= {1'b0, uperiod_i});
  assign strobe_o = edge_i | tick;
  assign period_o = vt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vt_q <= '0;
      uc_q <= '0;
    end else begin
      if (edge_i)               vt_q <= '0;
      else if (vt_q != VT_MAX)  vt_q <= vt_q + CW'(1);
      if (!fallback_o || tick)  uc_q <= '0;
      else                      uc_q <= uc_q + CW'(1);
    end
  end
endmodule

// File: rtl/hcc_pi_core.sv
module hcc_pi_core #(
  parameter int unsigned EW   = 8,
  parameter int unsigned GW   = 6,
  parameter int unsigned FRAC = 2,
  parameter int unsigned DW   = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [GW-1:0]        kp_i,
  input  logic [GW-1:0]        ki_i,
  output logic [DW-1:0]        vc_o
);
  localparam int unsigned PW = EW + GW + 1;
  localparam int unsigned SW = DW + PW + 2;
  localparam logic signed [SW-1:0] TOP = $signed({{(SW-DW){1'b0}}, {DW{1'b1}}});

  function automatic logic [DW-1:0] sat(input logic signed [SW-1:0] x);
    if (x[SW-1])     return '0;
    else if (x > TOP) return '1;
    else              return x[DW-1:0];
  endfunction

  logic signed [PW-1:0] p_term, i_term;
  logic signed [SW-1:0] ui_sum, vc_sum;
  logic [DW-1:0]        ui_q, vc_q, ui_next;

  assign p_term  = PW'(err_i) * PW'($signed({1'b0, kp_i}));
  assign i_term  = PW'(err_i) * PW'($signed({1'b0, ki_i}));
  assign ui_sum  = $signed(SW'(ui_q)) + SW'(i_term >>> FRAC);
  assign ui_next = sat(ui_sum);
  assign vc_sum  = SW'(p_term >>> FRAC) + $signed(SW'(ui_next));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ui_q <= '0;
      vc_q <= '0;
    end else if (strobe_i) begin
      ui_q <= ui_next;
      vc_q <= sat(vc_sum);
    end
  end

  assign vc_o = vc_q;
endmodule

// File: rtl/hcc_ref_sel.sv
module hcc_ref_sel
  import hcc_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ref_mode_e     mode_i,
  input  logic          gate_s_i,
  input  logic [DW-1:0] vc_i,
  input  logic [DW-1:0] band_i,
  output logic [DW-1:0] dac_o
);
  localparam int unsigned RW = DW + 2;

  function automatic logic [DW-1:0] sat(input logic signed [RW-1:0] x);
    if (x[RW-1])      return '0;
    else if (x[DW])   return '1;
    else              return x[DW-1:0];
  endfunction

  logic signed [RW-1:0] vc_x, band_x, half_x;
  logic [DW-1:0]        up_full, dn_full, up_half, dn_half, ref_d, dac_q;

  assign vc_x    = $signed({2'b00, vc_i});
  assign band_x  = $signed({2'b00, band_i});
  assign half_x  = $signed({3'b000, band_i[DW-1:1]});
  assign up_full = sat(vc_x + band_x);
  assign dn_full = sat(vc_x - band_x);
  assign up_half = sat(vc_x + half_x);
  assign dn_half = sat(vc_x - half_x);

  always_comb begin
    case (mode_i)
      MODE_VALLEY: ref_d = gate_s_i ? up_full : vc_i;
      MODE_AVG:    ref_d = gate_s_i ? up_half : dn_half;
      default:     ref_d = gate_s_i ? vc_i    : dn_full;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_q <= '0;
    else         dac_q <= ref_d;
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/hcc_volt_loop.sv
module hcc_volt_loop
  import hcc_pkg::*;
#(
  parameter int unsigned DW   = 10,
  parameter int unsigned EW   = 8,
  parameter int unsigned GW   = 6,
  parameter int unsigned FRAC = 2,
  parameter int unsigned CW   = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 gate_i,
  input  logic [1:0]           mode_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [GW-1:0]        kp_i,
  input  logic [GW-1:0]        ki_i,
  input  logic [DW-1:0]        band_i,
  input  logic [CW-1:0]        thresh_i,
  input  logic [CW-1:0]        uperiod_i,
  output logic [DW-1:0]        dac_o,
  output logic [CW-1:0]        period_o,
  output logic                 strobe_o,
  output logic                 fallback_o
);
  ref_mode_e     mode_q;
  logic          gate_s, edge_ev, strobe;
  logic [DW-1:0] vc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_PEAK;
    else if (strobe) mode_q <= ref_mode_e'(mode_i);
  end

  hcc_gate_edge #(.SYNC_STAGES(2)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_i),
    .use_fall_i(mode_q == MODE_VALLEY),
    .gate_s_o  (gate_s),
    .edge_o    (edge_ev)
  );

  hcc_sample_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_ev),
    .thresh_i  (thresh_i),
    .uperiod_i (uperiod_i),
    .period_o  (period_o),
    .fallback_o(fallback_o),
    .strobe_o  (strobe)
  );

  hcc_pi_core #(.EW(EW), .GW(GW), .FRAC(FRAC), .DW(DW)) u_pi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe),
    .err_i   (err_i),
    .kp_i    (kp_i),
    .ki_i    (ki_i),
    .vc_o    (vc_q)
  );

  hcc_ref_sel #(.DW(DW)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q),
    .gate_s_i(gate_s),
    .vc_i    (vc_q),
    .band_i  (band_i),
    .dac_o   (dac_o)
  );

  assign strobe_o = strobe;
endmodule

// File: rtl/hcc_volt_loop_chk.sv
module hcc_volt_loop_chk #(
  parameter int unsigned DW = 10,
  parameter int unsigned CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          strobe_o,
  input logic          fallback_o,
  input logic [CW-1:0] period_o,
  input logic [DW-1:0] dac_o,
  input logic          edge_ev,
  input logic          gate_s,
  input logic [1:0]    mode_q,
  input logic [DW-1:0] vc_q
);
  AST_PERIOD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_ev |=> period_o == '0); // R4
  AST_PERIOD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_ev && period_o != {CW{1'b1}}) |=> period_o == $past(period_o) + CW'(1)); // R4
  AST_PERIOD_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_ev && period_o == {CW{1'b1}}) |=> period_o == {CW{1'b1}}); // R4
  AST_NO_IDLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_ev && !fallback_o) |-> !strobe_o); // R5
  AST_VC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> $stable(vc_q)); // R8
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_o |=> $stable(mode_q)); // R12
  AST_PEAK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd0 && gate_s) |=> dac_o == $past(vc_q)); // R9
  AST_VALLEY_BOTTOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd1 && !gate_s) |=> dac_o == $past(vc_q)); // R10
endmodule

bind hcc_volt_loop hcc_volt_loop_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .strobe_o  (strobe_o),
  .fallback_o(fallback_o),
  .period_o  (period_o),
  .dac_o     (dac_o),
  .edge_ev   (edge_ev),
  .gate_s    (gate_s),
  .mode_q    (mode_q),
  .vc_q      (vc_q)
);

// File: tb/sim_hcc_volt_loop.sv
module sim_hcc_volt_loop;
  logic              clk = 1'b0;
  logic              rst_ni;
  logic              gate;
  logic [1:0]        mode;
  logic signed [7:0] err;
  logic [5:0]        kp, ki;
  logic [9:0]        band;
  logic [11:0]       thresh, uper;
  logic [9:0]        dac_o;
  logic [11:0]       period_o;
  logic              strobe_o, fallback_o;

  int n_chk = 0, n_err = 0, scount = 0;
  int m_ui = 0, m_vc = 0, m_mode = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hcc_volt_loop u0 (
    .clk_i(clk), .rst_ni(rst_ni), .gate_i(gate), .mode_i(mode), .err_i(err),
    .kp_i(kp), .ki_i(ki), .band_i(band), .thresh_i(thresh), .uperiod_i(uper),
    .dac_o(dac_o), .period_o(period_o), .strobe_o(strobe_o), .fallback_o(fallback_o)
  );

  function automatic int clampv(int x);
    if (x < 0)    return 0;
    if (x > 1023) return 1023;
    return x;
  endfunction

  function automatic int exp_dac(bit g);
    int b = int'(band);
    case (m_mode)
      1:       return g ? clampv(m_vc + b) : m_vc;
      2:       return g ? clampv(m_vc + b / 2) : clampv(m_vc - b / 2);
      default: return g ? m_vc : clampv(m_vc - b);
    endcase
  endfunction

  // reference model advanced on each observed strobe (R6, R7)
  always @(negedge clk) begin
    if (rst_ni && strobe_o) begin
      scount++;
      m_ui   = clampv(m_ui + ((int'(ki) * int'(err)) >>> 2));
      m_vc   = clampv(((int'(kp) * int'(err)) >>> 2) + m_ui);
      m_mode = int'(mode);
    end
  end

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic step_gate(bit v, int exp_strobes, string r);
    int s0;
    @(negedge clk);
    gate = v;
    s0 = scount;
    repeat (6) @(negedge clk);
    if (exp_strobes >= 0) chk({r, " strobes"}, scount - s0, exp_strobes);
    chk({r, " dac"}, int'(dac_o), exp_dac(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; gate = 1'b0; mode = 2'd0; err = '0;
    kp = 6'd8; ki = 6'd4; band = 10'd100; thresh = 12'd4000; uper = 12'd8;
    repeat (3) @(negedge clk);
    chk("R1 dac", int'(dac_o), 0);
    chk("R1 period", int'(period_o), 0);
    chk("R1 strobe", int'(strobe_o), 0);
    chk("R1 fallback", int'(fallback_o), 0);
    rst_ni = 1'b1;

    // peak mode PI sweep over three gain sets
    for (int g = 0; g < 3; g++) begin
      @(negedge clk);
      kp = (g == 0) ? 6'd8 : (g == 1) ? 6'd60 : 6'd2;
      ki = (g == 0) ? 6'd4 : (g == 1) ? 6'd30 : 6'd1;
      for (int e = -128; e <= 127; e += 15) begin
        @(negedge clk); err = 8'(e);
        step_gate(1'b1, 1, "R2 R6 R9 rise");
        step_gate(1'b0, 0, "R2 R9 fall");
        @(negedge clk); err = 8'(-e);
        repeat (4) @(negedge clk);
        chk("R8 hold", int'(dac_o), exp_dac(1'b0));
      end
    end
    // saturation limits with kp=2 from sweep end: use strong gains
    @(negedge clk); kp = 6'd60; ki = 6'd30; err = 8'sd127;
    step_gate(1'b1, 1, "R7 high");
    chk("R7 top", int'(dac_o), 1023);
    step_gate(1'b0, 0, "R7 fall");
    @(negedge clk); err = -8'sd128;
    step_gate(1'b1, 1, "R7 low");
    chk("R7 bottom", int'(dac_o), 0);
    @(negedge clk); kp = 6'd8; ki = 6'd4; err = 8'sd40;
    step_gate(1'b0, 0, "R2 fall");
    step_gate(1'b1, 1, "R6 rise");
    step_gate(1'b0, 0, "R9 fall");

    // mode change between strobes has no effect (R12), then valley (R3, R10)
    @(negedge clk); mode = 2'd1;
    repeat (6) @(negedge clk);
    chk("R12 dac unchanged", int'(dac_o), clampv(m_vc - int'(band)));
    step_gate(1'b1, 1, "R12 applied at strobe");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); err = 8'(30 * k - 50);
      step_gate(1'b0, 1, "R3 R10 fall");
      step_gate(1'b1, 0, "R3 R10 rise");
    end

    // average mode with odd band (R11)
    @(negedge clk); mode = 2'd2; band = 10'd101; err = 8'sd25;
    step_gate(1'b0, 1, "R11 enter");
    step_gate(1'b1, 1, "R11 rise");
    step_gate(1'b0, 0, "R11 fall");
    @(negedge clk); err = -8'sd20;
    step_gate(1'b1, 1, "R11 rise2");
    // code 3 acts as peak
    @(negedge clk); mode = 2'd3;
    step_gate(1'b0, 0, "R11 fall3");
    step_gate(1'b1, 1, "R11 alias rise");
    step_gate(1'b0, 0, "R11 alias fall");

    // fallback timing (R4, R5)
    @(negedge clk); mode = 2'd0; err = '0;
    step_gate(1'b1, 1, "R2 back to peak");
    step_gate(1'b0, 0, "R2 fall");
    @(negedge clk); thresh = 12'd20; uper = 12'd8; gate = 1'b1;
    for (int w = 0; w < 20 && !strobe_o; w++) @(negedge clk);
    begin
      int cnt = 0;
      for (int j = 0; j < 100; j++) begin
        @(negedge clk);
        if (strobe_o) cnt++;
        if (j == 0 || j == 19 || j == 57) chk("R4 period", int'(period_o), j);
        if (j == 19) chk("R5 fallback off", int'(fallback_o), 0);
        if (j == 20) chk("R5 fallback on", int'(fallback_o), 1);
      end
      chk("R5 uniform strobes", cnt, 10);
    end
    step_gate(1'b0, -1, "R5 fall in fallback");
    chk("R5 still fallback", int'(fallback_o), 1);
    step_gate(1'b1, -1, "R5 edge ends fallback");
    chk("R5 fallback cleared", int'(fallback_o), 0);
    chk("R4 period restart", int'(period_o), 3);

    // counter saturation (R4)
    @(negedge clk); thresh = 12'd4095;
    repeat (4200) @(negedge clk);
    chk("R4 saturate", int'(period_o), 4095);
    chk("R5 fallback at max", int'(fallback_o), 1);

    // uniform period 0 ticks every clock (R5)
    step_gate(1'b0, -1, "R5 fall");
    @(negedge clk); thresh = 12'd10; uper = 12'd0; gate = 1'b1;
    for (int w = 0; w < 20 && fallback_o; w++) @(negedge clk);
    chk("R4 period zero", int'(period_o), 0);
    begin
      int cnt = strobe_o ? 1 : 0;
      for (int j = 1; j < 30; j++) begin
        @(negedge clk);
        if (strobe_o) cnt++;
      end
      chk("R5 every-clock strobes", cnt, 20);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule